// File: doc/BRIEF.md
# Asynchronous SRAM Access Controller

This block sits between a synchronous host and an asynchronous static RAM that has a 20-bit word address, a 16-bit data word and one active-low enable per byte lane. The host presents a single-cycle request with a read/write flag, an address, write data and a per-lane mask. The controller then produces the chip-enable, write-enable, output-enable and byte-enable strobes with the spacing the memory needs. Every spacing is a whole number of clock cycles. Each count is the ceiling of a nanosecond figure divided by the clock period, with a floor of one cycle.

A write holds the write strobe low long enough for the strobe width, the data setup time and the address-to-end time. The cycle then stretches to the minimum write cycle. A read holds output enable low until the slowest of the address, chip-enable and output-enable access times has passed. It captures the word on that edge and returns it with a one-cycle valid pulse. The controller drives the shared data bus only while output enable is high. After a read it waits for the output-release time before it switches its drivers on. Between accesses the chip stays deselected so the memory can drop into standby.

Top module: `sram_async_ctrl`

## Requirements
- R1: After reset the chip is deselected (first chip enable high, second low), write and output enables are high, all byte enables are high, the data drivers are off, busy is low and read-valid is low.
- R2: A write holds the write strobe low for exactly ceil(max(40, 25, 40) ns / clock) cycles (4 at 10 ns), with both chip enables asserted, output enable high and the data drivers on throughout.
- R3: For a write, busy is high from the cycle after acceptance for ceil(55 ns / clock) cycles (6 at 10 ns) and is then low again.
- R4: A read holds output enable low and write enable high. It captures the bus ceil(max(55, 55, 25) ns / clock) cycles after acceptance (6 at 10 ns), so read-valid appears in the 7th cycle after acceptance. Read-valid lasts exactly one cycle.
- R5: Byte mask bit 0 selects bits 7:0 (byte enable index 0) and bit 1 selects bits 15:8 (index 1). A write changes only the lanes whose mask bit is set.
- R6: On a read, lanes whose mask bit is clear return zero in the read data, whatever the bus carries.
- R7: A request whose mask is all zero asserts no memory strobe and leaves busy low. For a write it changes nothing. For a read it raises read-valid in the next cycle with zero data.
- R8: After a read, the data drivers switch on no sooner than ceil(20 ns / clock) cycles (2 at 10 ns) after output enable has returned high.
- R9: Outside an access the chip is deselected with all byte enables high.
- R10: The data drivers are never on while output enable is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request strobe, taken when busy is low |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | AW | Word address |
| req_wdata | input | DW | Write data |
| req_mask | input | DW/8 | Per-lane mask, bit i selects bits 8i+7:8i |
| busy | output | 1 | Controller occupied, no new request taken |
| rd_valid | output | 1 | One-cycle pulse with returned read data |
| rd_data | output | DW | Read data, unmasked lanes zero |
| mem_ce1_n | output | 1 | Chip enable, active low |
| mem_ce2 | output | 1 | Chip enable, active high |
| mem_we_n | output | 1 | Write enable, active low |
| mem_oe_n | output | 1 | Output enable, active low |
| mem_be_n | output | DW/8 | Byte lane enables, active low |
| mem_addr | output | AW | Memory address |
| mem_dq_out | output | DW | Data driven to the memory |
| mem_dq_oe | output | 1 | Drive enable for mem_dq_out |
| mem_dq_in | input | DW | Data returned from the memory |

## Verification
On every clock the assertions check several rules. The write strobe appears only with the chip selected, a lane enabled and the drivers on. Drivers and output enable are never active together. The chip is deselected whenever the sequencer is idle. A chip select always lies inside a busy window. A zero-mask request leaves the chip deselected. The drivers only come on after at least two cycles of released output enable. Only the bench scenarios can show the exact pulse and cycle lengths, the capture edge (its memory model returns valid data only after the access time) and the lane merging on a partial write. They also show the measured gap between a read and the next write, and that a zero-mask write leaves the stored word untouched.

// File: rtl/sram_ctrl_pkg.sv
package sram_ctrl_pkg;

   typedef enum logic [2:0] {
      S_IDLE     = 3'd0,
      S_RD_ACT   = 3'd1,
      S_WR_TURN  = 3'd2,
      S_WR_PULSE = 3'd3,
      S_WR_RECOV = 3'd4
   } seq_state_t;

   // ceiling of ns / period, never below one cycle
   function automatic int unsigned ns_to_cycles(input int unsigned ns,
                                                input int unsigned period);
      int unsigned c;
      c = (ns + period - 1) / period;
      return (c == 0) ? 1 : c;
   endfunction

   function automatic int unsigned umax(input int unsigned a, input int unsigned b);
      return (a > b) ? a : b;
   endfunction

endpackage

// File: rtl/sram_lane_gate.sv
module sram_lane_gate #(
   parameter int unsigned LANES  = 2,
   parameter int unsigned LANE_W = 8
) (
   input  logic [LANES*LANE_W-1:0] din,
   input  logic [LANES-1:0]        keep,
   output logic [LANES*LANE_W-1:0] dout
);
   if (LANES < 1)  begin : g_bad_lanes  $error("LANES must be at least 1");  end
   if (LANE_W < 1) begin : g_bad_width  $error("LANE_W must be at least 1"); end

   for (genvar i = 0; i < LANES; i++) begin : g_lane
      assign dout[i*LANE_W +: LANE_W] = keep[i] ? din[i*LANE_W +: LANE_W] : '0;
   end
endmodule

// File: rtl/sram_turn_timer.sv
module sram_turn_timer #(
   parameter int unsigned CYCLES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic load,
   output logic active
);
   localparam int unsigned TW = $clog2(CYCLES + 1);

   if (CYCLES < 1) begin : g_bad_cycles $error("CYCLES must be at least 1"); end

   logic [TW-1:0] remain;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)              remain <= '0;
      else if (load)           remain <= TW'(CYCLES);
      else if (remain != '0)   remain <= remain - TW'(1);
   end

   assign active = (remain != '0);

   // R8: a load always opens a release window
   a_r8_load_opens_window: assert property (@(posedge clk) disable iff (!rst_n)
      load |=> active);
endmodule

// File: rtl/sram_async_ctrl.sv
module sram_async_ctrl
   import sram_ctrl_pkg::*;
#(
   parameter int unsigned AW            = 20,
   parameter int unsigned DW            = 16,
   parameter int unsigned CLK_PERIOD_NS = 10,
   parameter int unsigned T_WC_NS       = 55,
   parameter int unsigned T_PWE_NS      = 40,
   parameter int unsigned T_AW_NS       = 40,
   parameter int unsigned T_SD_NS       = 25,
   parameter int unsigned T_RC_NS       = 55,
   parameter int unsigned T_AA_NS       = 55,
   parameter int unsigned T_DOE_NS      = 25,
   parameter int unsigned T_HZOE_NS     = 20
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   input  logic              req_write,
   input  logic [AW-1:0]     req_addr,
   input  logic [DW-1:0]     req_wdata,
   input  logic [DW/8-1:0]   req_mask,
   output logic              busy,
   output logic              rd_valid,
   output logic [DW-1:0]     rd_data,
   output logic              mem_ce1_n,
   output logic              mem_ce2,
   output logic              mem_we_n,
   output logic              mem_oe_n,
   output logic [DW/8-1:0]   mem_be_n,
   output logic [AW-1:0]     mem_addr,
   output logic [DW-1:0]     mem_dq_out,
   output logic              mem_dq_oe,
   input  logic [DW-1:0]     mem_dq_in
);
   localparam int unsigned NL    = DW / 8;
   localparam int unsigned C_WP  = umax(ns_to_cycles(T_PWE_NS, CLK_PERIOD_NS),
                                   umax(ns_to_cycles(T_SD_NS, CLK_PERIOD_NS),
                                        ns_to_cycles(T_AW_NS, CLK_PERIOD_NS)));
   localparam int unsigned C_WC  = ns_to_cycles(T_WC_NS, CLK_PERIOD_NS);
   localparam int unsigned C_REC = (C_WC > C_WP) ? (C_WC - C_WP) : 1;
   localparam int unsigned C_RD  = umax(ns_to_cycles(T_RC_NS, CLK_PERIOD_NS),
                                   umax(ns_to_cycles(T_AA_NS, CLK_PERIOD_NS),
                                        ns_to_cycles(T_DOE_NS, CLK_PERIOD_NS)));
   localparam int unsigned C_HZ  = ns_to_cycles(T_HZOE_NS, CLK_PERIOD_NS);
   localparam int unsigned C_MAX = umax(C_WP, umax(C_REC, C_RD));
   localparam int unsigned CW    = $clog2(C_MAX + 1);

   if (DW % 8 != 0 || DW == 0) begin : g_bad_dw  $error("DW must be a nonzero multiple of 8"); end
   if (AW < 1)                 begin : g_bad_aw  $error("AW must be at least 1"); end
   if (CLK_PERIOD_NS == 0)     begin : g_bad_clk $error("CLK_PERIOD_NS must be nonzero"); end

   seq_state_t     state;
   logic [CW-1:0]  cnt;
   logic [NL-1:0]  lat_mask;
   logic           turn_load;
   logic           turn_busy;
   logic [DW-1:0]  rd_gated;

   assign turn_load = (state == S_RD_ACT) && (cnt == '0);

   sram_turn_timer #(.CYCLES(C_HZ)) u_turn (
      .clk    (clk),
      .rst_n  (rst_n),
      .load   (turn_load),
      .active (turn_busy)
   );

   sram_lane_gate #(.LANES(NL), .LANE_W(8)) u_rd_gate (
      .din  (mem_dq_in),
      .keep (lat_mask),
      .dout (rd_gated)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state      <= S_IDLE;
         cnt        <= '0;
         lat_mask   <= '0;
         busy       <= 1'b0;
         rd_valid   <= 1'b0;
         rd_data    <= '0;
         mem_ce1_n  <= 1'b1;
         mem_ce2    <= 1'b0;
         mem_we_n   <= 1'b1;
         mem_oe_n   <= 1'b1;
         mem_be_n   <= '1;
         mem_addr   <= '0;
         mem_dq_out <= '0;
         mem_dq_oe  <= 1'b0;
      end else begin
         rd_valid <= 1'b0;
         unique case (state)
            S_IDLE: begin
               if (req_valid) begin
                  if (req_mask == '0) begin
                     if (!req_write) begin
                        rd_valid <= 1'b1;
                        rd_data  <= '0;
                     end
                  end else begin
                     mem_addr   <= req_addr;
                     mem_dq_out <= req_wdata;
                     lat_mask   <= req_mask;
                     busy       <= 1'b1;
                     if (!req_write) begin
                        mem_ce1_n <= 1'b0;
                        mem_ce2   <= 1'b1;
                        mem_oe_n  <= 1'b0;
                        mem_be_n  <= ~req_mask;
                        cnt       <= CW'(C_RD - 1);
                        state     <= S_RD_ACT;
                     end else if (turn_busy) begin
                        state     <= S_WR_TURN;
                     end else begin
                        mem_ce1_n <= 1'b0;
                        mem_ce2   <= 1'b1;
                        mem_we_n  <= 1'b0;
                        mem_be_n  <= ~req_mask;
                        mem_dq_oe <= 1'b1;
                        cnt       <= CW'(C_WP - 1);
                        state     <= S_WR_PULSE;
                     end
                  end
               end
            end
            S_RD_ACT: begin
               if (cnt == '0) begin
                  rd_data   <= rd_gated;
                  rd_valid  <= 1'b1;
                  mem_ce1_n <= 1'b1;
                  mem_ce2   <= 1'b0;
                  mem_oe_n  <= 1'b1;
                  mem_be_n  <= '1;
                  busy      <= 1'b0;
                  state     <= S_IDLE;
               end else begin
                  cnt <= cnt - CW'(1);
               end
            end
            S_WR_TURN: begin
               if (!turn_busy) begin
                  mem_ce1_n <= 1'b0;
                  mem_ce2   <= 1'b1;
                  mem_we_n  <= 1'b0;
                  mem_be_n  <= ~lat_mask;
                  mem_dq_oe <= 1'b1;
                  cnt       <= CW'(C_WP - 1);
                  state     <= S_WR_PULSE;
               end
            end
            S_WR_PULSE: begin
               if (cnt == '0) begin
                  mem_we_n  <= 1'b1;
                  mem_ce1_n <= 1'b1;
                  mem_ce2   <= 1'b0;
                  mem_be_n  <= '1;
                  cnt       <= CW'(C_REC - 1);
                  state     <= S_WR_RECOV;
               end else begin
                  cnt <= cnt - CW'(1);
               end
            end
            S_WR_RECOV: begin
               if (cnt == '0) begin
                  mem_dq_oe <= 1'b0;
                  busy      <= 1'b0;
                  state     <= S_IDLE;
               end else begin
                  cnt <= cnt - CW'(1);
               end
            end
            default: state <= S_IDLE;
         endcase
      end
   end

   // R2: write strobe only inside a selected, lane-enabled, driven window
   a_r2_write_window: assert property (@(posedge clk) disable iff (!rst_n)
      !mem_we_n |-> (!mem_ce1_n && mem_ce2 && (mem_be_n != '1) && mem_dq_oe && mem_oe_n));

   // R10: no driver while the memory may drive
   a_r10_no_contention: assert property (@(posedge clk) disable iff (!rst_n)
      mem_dq_oe |-> mem_oe_n);

   // R4: read strobes keep write enable high
   a_r4_read_strobes: assert property (@(posedge clk) disable iff (!rst_n)
      !mem_oe_n |-> (mem_we_n && !mem_ce1_n && mem_ce2));

   // R3: a selected chip always lies inside a busy window
   a_r3_select_in_busy: assert property (@(posedge clk) disable iff (!rst_n)
      !mem_ce1_n |-> busy);

   // R9: idle sequencer leaves the chip deselected
   a_r9_idle_deselect: assert property (@(posedge clk) disable iff (!rst_n)
      (state == S_IDLE) |-> (mem_ce1_n && !mem_ce2 && (mem_be_n == '1)));

   // R7: zero-mask request strobes nothing
   a_r7_zero_mask_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      (state == S_IDLE && req_valid && req_mask == '0) |=> (mem_ce1_n && !busy));

   // R8: drivers rise only after output enable has been high for two samples
   a_r8_release_gap: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(mem_dq_oe) |-> ($past(mem_oe_n) && $past(mem_oe_n, 2)));
endmodule

// File: tb/sram_async_ctrl_bench.sv
`timescale 1ns/1ps
module sram_async_ctrl_bench;
   localparam int CLK_PERIOD = 10;
   localparam int AW = 20;
   localparam int DW = 16;
   // expected counts from the requirements at a 10 ns clock
   localparam int EXP_WE_LOW = 4;
   localparam int EXP_WBUSY  = 6;
   localparam int EXP_ACCESS = 6;
   localparam int EXP_GAP    = 2;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic req_valid = 1'b0, req_write = 1'b0;
   logic [AW-1:0] req_addr = '0;
   logic [DW-1:0] req_wdata = '0;
   logic [1:0] req_mask = '0;
   logic busy, rd_valid;
   logic [DW-1:0] rd_data;
   logic mem_ce1_n, mem_ce2, mem_we_n, mem_oe_n, mem_dq_oe;
   logic [1:0] mem_be_n;
   logic [AW-1:0] mem_addr;
   logic [DW-1:0] mem_dq_out, mem_dq_in;

   int tests = 0, fails = 0;
   int cyc = 0, rd_age = 0, contention = 0, sel_cycles = 0;
   int last_oe_rise = -100, min_gap = 1000;
   logic prev_oe_n = 1'b1, prev_dq_oe = 1'b0;
   logic [15:0] mem [0:255];

   always #(CLK_PERIOD/2) clk = ~clk;

   sram_async_ctrl u_sram_async_ctrl (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
      .req_addr(req_addr), .req_wdata(req_wdata), .req_mask(req_mask),
      .busy(busy), .rd_valid(rd_valid), .rd_data(rd_data),
      .mem_ce1_n(mem_ce1_n), .mem_ce2(mem_ce2), .mem_we_n(mem_we_n), .mem_oe_n(mem_oe_n),
      .mem_be_n(mem_be_n), .mem_addr(mem_addr), .mem_dq_out(mem_dq_out),
      .mem_dq_oe(mem_dq_oe), .mem_dq_in(mem_dq_in));

   wire sel = !mem_ce1_n && mem_ce2;

   // memory model: writes land while the write window is open
   always @(posedge clk) begin
      cyc <= cyc + 1;
      if (sel && !mem_we_n && mem_dq_oe) begin
         if (!mem_be_n[0]) mem[mem_addr[7:0]][7:0]  <= mem_dq_out[7:0];
         if (!mem_be_n[1]) mem[mem_addr[7:0]][15:8] <= mem_dq_out[15:8];
      end
      if (sel && !mem_oe_n && mem_we_n) rd_age <= rd_age + 1;
      else rd_age <= 0;
      if (mem_dq_oe && !mem_oe_n) contention <= contention + 1;
      if (sel) sel_cycles <= sel_cycles + 1;
   end

   // read data becomes valid only once the access time has elapsed
   always_comb begin
      mem_dq_in = 16'hDEAD;
      if (sel && !mem_oe_n && mem_we_n && (rd_age + 1 >= EXP_ACCESS)) begin
         mem_dq_in[7:0]  = mem_be_n[0] ? 8'hEE : mem[mem_addr[7:0]][7:0];
         mem_dq_in[15:8] = mem_be_n[1] ? 8'hEE : mem[mem_addr[7:0]][15:8];
      end
   end

   // turnaround monitor, sampled away from the active edge
   always @(negedge clk) begin
      if (mem_oe_n && !prev_oe_n) last_oe_rise = cyc;
      if (mem_dq_oe && !prev_dq_oe && (cyc - last_oe_rise) < min_gap) min_gap = cyc - last_oe_rise;
      prev_oe_n  = mem_oe_n;
      prev_dq_oe = mem_dq_oe;
   end

   task automatic check(input bit ok, input string req, input int act, input int exp);
      tests++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
      end
   endtask

   task automatic do_write(input logic [AW-1:0] a, input logic [15:0] d, input logic [1:0] m,
                           output int we_low, output int busy_cnt);
      while (busy) @(negedge clk);
      req_valid = 1'b1; req_write = 1'b1; req_addr = a; req_wdata = d; req_mask = m;
      @(negedge clk);
      req_valid = 1'b0;
      we_low = 0; busy_cnt = 0;
      while (busy) begin
         busy_cnt++;
         if (!mem_we_n) begin
            we_low++;
            check(mem_dq_oe && mem_oe_n && mem_dq_out == d && mem_be_n == ~m, "R2", mem_be_n, ~m);
         end
         @(negedge clk);
      end
   endtask

   task automatic do_read(input logic [AW-1:0] a, input logic [1:0] m,
                          output logic [15:0] d, output int lat);
      while (busy) @(negedge clk);
      req_valid = 1'b1; req_write = 1'b0; req_addr = a; req_mask = m;
      @(negedge clk);
      req_valid = 1'b0;
      lat = 1;
      while (!rd_valid && lat < 50) begin
         @(negedge clk);
         lat++;
      end
      d = rd_data;
   endtask

   task automatic t_reset;
      check(mem_ce1_n && !mem_ce2 && mem_we_n && mem_oe_n && mem_be_n == 2'b11 && !mem_dq_oe,
            "R1", {mem_ce1_n, mem_ce2, mem_we_n, mem_oe_n, mem_be_n, mem_dq_oe}, 7'b1011110);
      check(!busy && !rd_valid, "R1", {busy, rd_valid}, 0);
   endtask

   task automatic t_full_write_read;
      int wl, bc, lat; logic [15:0] d;
      do_write(20'h00010, 16'hA55A, 2'b11, wl, bc);
      check(wl == EXP_WE_LOW, "R2", wl, EXP_WE_LOW);
      check(bc == EXP_WBUSY, "R3", bc, EXP_WBUSY);
      check(mem_ce1_n && !mem_ce2 && mem_be_n == 2'b11, "R9", mem_ce1_n, 1);
      do_read(20'h00010, 2'b11, d, lat);
      check(lat == EXP_ACCESS + 1, "R4", lat, EXP_ACCESS + 1);
      check(d == 16'hA55A, "R4", d, 16'hA55A);
      @(negedge clk);
      check(!rd_valid, "R4", rd_valid, 0);
      check(mem_ce1_n && mem_oe_n && mem_be_n == 2'b11, "R9", mem_oe_n, 1);
   endtask

   task automatic t_byte_write;
      int wl, bc, lat; logic [15:0] d;
      do_write(20'h00020, 16'h1234, 2'b11, wl, bc);
      do_write(20'h00020, 16'hBEEF, 2'b01, wl, bc);
      do_read(20'h00020, 2'b11, d, lat);
      check(d == 16'h12EF, "R5", d, 16'h12EF);
      do_write(20'h00020, 16'hCAFE, 2'b10, wl, bc);
      do_read(20'h00020, 2'b11, d, lat);
      check(d == 16'hCAEF, "R5", d, 16'hCAEF);
   endtask

   task automatic t_byte_read;
      int lat; logic [15:0] d;
      do_read(20'h00020, 2'b10, d, lat);
      check(d == 16'hCA00, "R6", d, 16'hCA00);
      do_read(20'h00020, 2'b01, d, lat);
      check(d == 16'h00EF, "R6", d, 16'h00EF);
   endtask

   task automatic t_zero_mask;
      int wl, bc, lat, s0; logic [15:0] d;
      s0 = sel_cycles;
      do_write(20'h00020, 16'h0000, 2'b00, wl, bc);
      check(bc == 0 && wl == 0, "R7", bc, 0);
      do_read(20'h00020, 2'b00, d, lat);
      check(lat == 1 && d == 16'h0000, "R7", lat, 1);
      check(sel_cycles == s0, "R7", sel_cycles - s0, 0);
      do_read(20'h00020, 2'b11, d, lat);
      check(d == 16'hCAEF, "R7", d, 16'hCAEF);
   endtask

   task automatic t_turnaround;
      int wl, bc, lat; logic [15:0] d;
      min_gap = 1000;
      do_read(20'h00010, 2'b11, d, lat);
      do_write(20'h00030, 16'h7E57, 2'b11, wl, bc);
      check(min_gap >= EXP_GAP, "R8", min_gap, EXP_GAP);
      do_read(20'h00030, 2'b11, d, lat);
      check(d == 16'h7E57, "R8", d, 16'h7E57);
   endtask

   bit done = 0;
   initial begin
      for (int i = 0; i < 256; i++) mem[i] = 16'(i * 257) ^ 16'h5A3C;
      repeat (3) @(negedge clk);
      t_reset();
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_full_write_read();
      t_byte_write();
      t_byte_read();
      t_zero_mask();
      t_turnaround();
      check(contention == 0, "R10", contention, 0);
      if (!done) begin
         done = 1;
         $display("  [TB] %0d tests run, %0d failed", tests, fails);
         $finish;
      end
   end

   initial begin
      #(CLK_PERIOD * 100000);
      if (!done) begin
         done = 1;
         tests++; fails++;
         $display("FAIL watchdog actual=0x0 expected=0x1");
         $display("  [TB] %0d tests run, %0d failed", tests, fails);
         $finish;
      end
   end
endmodule